// File: doc/BRIEF.md
# DDR3 Command Timing Checker

This block is a passive monitor for a DDR3 command bus. On every rising clock edge it reads the clock-enable, chip-select, row strobe, column strobe, write-enable, bank-select and address pins. It decodes the command carried there and keeps a model of each of the eight banks. The model holds whether a row is open and a set of down-counters that count the cycles left until each minimum spacing rule is met. A global activate-spacing counter and a rolling window of the most recent activates sit next to the bank models.

When a command breaks a bank-state rule or arrives too early, the block raises a registered violation flag for one cycle. The flag carries a 4-bit reason code and the bank that caused it. Every timing limit is a parameter given in clock cycles. The checker sits beside a controller or a bus model in simulation or in an on-chip debug fabric. It updates its bank model from every decoded command, including one that it flags, so that later checks follow what the bus actually did.

Top module: `ddr_cmd_checker`

## Requirements
- R1: A command is taken only when cke=1 and cs_n=0. Otherwise the cycle counts as deselect: it changes no state and raises no violation. With a command taken, {ras_n,cas_n,we_n} decodes as: 011 ACTIVATE, 101 READ, 100 WRITE, 010 PRECHARGE, 000 MODE REGISTER SET, 110 ZQ calibration, 111 NOP.
- R2: A READ or WRITE to a bank with no open row gives code 1.
- R3: A READ or WRITE less than T_RCD (default 14) cycles after that bank's ACTIVATE gives code 2.
- R4: An ACTIVATE to a bank whose row is already open gives code 3.
- R5: Two ACTIVATEs to the same bank less than T_RC (default 50) cycles apart give code 4.
- R6: An ACTIVATE to a bank other than the previous ACTIVATE's bank, less than T_RRD (default 6) cycles after that previous ACTIVATE, gives code 5.
- R7: An ACTIVATE issued while the four previous ACTIVATEs all fall within the last T_FAW (default 27) cycles gives code 6.
- R8: An ACTIVATE less than T_RP (default 14) cycles after the bank closed gives code 7. A PRECHARGE to an idle bank changes nothing.
- R9: A PRECHARGE to an open bank less than T_RAS (default 36) cycles after its ACTIVATE gives code 8.
- R10: A PRECHARGE to an open bank less than T_RTP (default 8) cycles after its last READ gives code 9. Code 8 wins over code 9 when both apply.
- R11: A READ or WRITE with addr[10]=1 closes the bank at once. Its T_RP window starts at the earliest legal PRECHARGE time: T_RAS after the ACTIVATE, and for a READ also T_RTP after the READ.
- R12: A MODE REGISTER SET or ZQ command while any bank is open gives code 10, reported against the lowest-numbered open bank.
- R13: viol_o, viol_code_o and viol_bank_o are registered and appear in the cycle after the offending command. They are all zero when there is no violation and after reset. For ACTIVATE the checks are ranked 3, 4, 5, 6, 7, and the first failing check gives the code.
- R14: A PRECHARGE with addr[10]=1 targets every bank. It reports the lowest-numbered open bank that breaks R9 or R10, and it closes all banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank select |
| addr | input | 16 | Address pins; bit 10 carries auto-precharge and precharge-all |
| viol_o | output | 1 | One-cycle violation flag |
| viol_code_o | output | 4 | Reason code, 0 when idle |
| viol_bank_o | output | 3 | Bank that broke the rule |

## Verification
The hardest case to reach is the closed-but-not-ready state left behind by auto-precharge. Its tRP window opens at a computed future time that depends on both the remaining tRAS and the tRTP of the closing READ. The bench places the auto-precharge READ after tRAS has run out, so the tRTP term decides the window. It then places an ACTIVATE one cycle before and exactly at the computed limit. The rolling four-activate window and the precharge-all bank scan are reached the same way: directed sequences of activates at exact cycle spacings around each limit.

// File: rtl/ddrchk_pkg.sv
package ddrchk_pkg;
  typedef enum logic [2:0] {
    CMD_DES, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_MRS, CMD_ZQ
  } cmd_e;

  localparam logic [3:0] RSN_NONE    = 4'd0;
  localparam logic [3:0] RSN_IDLE_RW = 4'd1;
  localparam logic [3:0] RSN_RCD     = 4'd2;
  localparam logic [3:0] RSN_OPEN    = 4'd3;
  localparam logic [3:0] RSN_RC      = 4'd4;
  localparam logic [3:0] RSN_RRD     = 4'd5;
  localparam logic [3:0] RSN_FAW     = 4'd6;
  localparam logic [3:0] RSN_RP      = 4'd7;
  localparam logic [3:0] RSN_RAS     = 4'd8;
  localparam logic [3:0] RSN_RTP     = 4'd9;
  localparam logic [3:0] RSN_CFG     = 4'd10;
endpackage

// File: rtl/ddrchk_decode.sv
module ddrchk_decode
  import ddrchk_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd_o
);
  always_comb begin
    if (!cke || cs_n) begin
      cmd_o = CMD_DES;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b000:  cmd_o = CMD_MRS;
        3'b110:  cmd_o = CMD_ZQ;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddrchk_bank.sv
module ddrchk_bank #(
  parameter int CNT_W = 8,
  parameter int T_RCD = 14,
  parameter int T_RC  = 50,
  parameter int T_RAS = 36,
  parameter int T_RTP = 8,
  parameter int T_RP  = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic act_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic pre_i,
  input  logic ap_i,
  output logic open_o,
  output logic rcd_busy_o,
  output logic rc_busy_o,
  output logic ras_busy_o,
  output logic rtp_busy_o,
  output logic rp_busy_o
);
  localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] L_RC  = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] L_RAS = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] W_RTP = CNT_W'(T_RTP);
  localparam logic [CNT_W-1:0] L_RTP = CNT_W'(T_RTP - 1);

  logic             open_q;
  logic [CNT_W-1:0] rcd_q, rc_q, ras_q, rtp_q, rp_q;

  function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  // ras_q holds the cycles still needed before a precharge is legal
  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      rcd_q  <= '0;
      rc_q   <= '0;
      ras_q  <= '0;
      rtp_q  <= '0;
      rp_q   <= '0;
    end else begin
      rcd_q <= dec(rcd_q);
      rc_q  <= dec(rc_q);
      ras_q <= dec(ras_q);
      rtp_q <= dec(rtp_q);
      rp_q  <= dec(rp_q);
      if (act_i) begin
        open_q <= 1'b1;
        rcd_q  <= L_RCD;
        rc_q   <= L_RC;
        ras_q  <= L_RAS;
      end
      if (rd_i) begin
        rtp_q <= L_RTP;
        if (ap_i) begin
          open_q <= 1'b0;
          rp_q   <= ((ras_q > W_RTP) ? ras_q : W_RTP) + L_RP;
        end
      end
      if (wr_i && ap_i) begin
        open_q <= 1'b0;
        rp_q   <= ras_q + L_RP;
      end
      if (pre_i && open_q) begin
        open_q <= 1'b0;
        rp_q   <= L_RP;
      end
    end
  end

  assign open_o     = open_q;
  assign rcd_busy_o = (rcd_q != '0);
  assign rc_busy_o  = (rc_q != '0);
  assign ras_busy_o = (ras_q != '0);
  assign rtp_busy_o = (rtp_q != '0);
  assign rp_busy_o  = (rp_q != '0);
endmodule

// File: rtl/ddrchk_act_win.sv
module ddrchk_act_win #(
  parameter int BA_W     = 3,
  parameter int CNT_W    = 8,
  parameter int T_RRD    = 6,
  parameter int T_FAW    = 27,
  parameter int FAW_ACTS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            act_i,
  input  logic [BA_W-1:0] ba_i,
  output logic            rrd_hit_o,
  output logic            faw_hit_o
);
  localparam logic [CNT_W-1:0] L_RRD = CNT_W'(T_RRD - 1);
  localparam logic [CNT_W-1:0] L_FAW = CNT_W'(T_FAW - 1);

  logic [CNT_W-1:0] rrd_q;
  logic [BA_W-1:0]  last_ba_q;
  logic [CNT_W-1:0] slot_q [FAW_ACTS];

  function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] x);
    return (x == '0) ? '0 : x - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rrd_q     <= '0;
      last_ba_q <= '0;
    end else if (act_i) begin
      rrd_q     <= L_RRD;
      last_ba_q <= ba_i;
    end else begin
      rrd_q <= dec(rrd_q);
    end
  end

  // slot k holds the window time left for the (k+1)-th most recent activate
  for (genvar k = 0; k < FAW_ACTS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[k] <= '0;
      end else if (act_i) begin
        if (k == 0) slot_q[k] <= L_FAW;
        else        slot_q[k] <= dec(slot_q[(k == 0) ? 0 : k-1]);
      end else begin
        slot_q[k] <= dec(slot_q[k]);
      end
    end
  end

  assign rrd_hit_o = (rrd_q != '0) && (ba_i != last_ba_q);
  assign faw_hit_o = (slot_q[FAW_ACTS-1] != '0);
endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker
  import ddrchk_pkg::*;
#(
  parameter int BA_W     = 3,
  parameter int ADDR_W   = 16,
  parameter int AP_BIT   = 10,
  parameter int T_RCD    = 14,
  parameter int T_RC     = 50,
  parameter int T_RRD    = 6,
  parameter int T_FAW    = 27,
  parameter int FAW_ACTS = 4,
  parameter int T_RAS    = 36,
  parameter int T_RTP    = 8,
  parameter int T_RP     = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              viol_o,
  output logic [3:0]        viol_code_o,
  output logic [BA_W-1:0]   viol_bank_o
);
  localparam int NBANK = 1 << BA_W;
  localparam int CNT_W = $clog2(T_RC + T_RAS + T_RTP + T_RP + T_FAW + T_RCD + T_RRD + 1);

  cmd_e cmd;
  logic ap;
  logic unused_addr;
  assign ap          = addr[AP_BIT];
  assign unused_addr = ^addr;

  ddrchk_decode u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd_o(cmd)
  );

  logic [NBANK-1:0] bk_open, bk_rcd, bk_rc, bk_ras, bk_rtp, bk_rp, pre_tgt;
  logic rrd_hit, faw_hit;

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic sel;
    assign sel        = (ba == BA_W'(i));
    assign pre_tgt[i] = (cmd == CMD_PRE) && (ap || sel);
    ddrchk_bank #(
      .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RC(T_RC), .T_RAS(T_RAS), .T_RTP(T_RTP), .T_RP(T_RP)
    ) u_bank (
      .clk(clk), .rst(rst),
      .act_i(sel && cmd == CMD_ACT),
      .rd_i(sel && cmd == CMD_RD),
      .wr_i(sel && cmd == CMD_WR),
      .pre_i(pre_tgt[i]),
      .ap_i(ap),
      .open_o(bk_open[i]), .rcd_busy_o(bk_rcd[i]), .rc_busy_o(bk_rc[i]),
      .ras_busy_o(bk_ras[i]), .rtp_busy_o(bk_rtp[i]), .rp_busy_o(bk_rp[i])
    );
  end

  ddrchk_act_win #(
    .BA_W(BA_W), .CNT_W(CNT_W), .T_RRD(T_RRD), .T_FAW(T_FAW), .FAW_ACTS(FAW_ACTS)
  ) u_win (
    .clk(clk), .rst(rst), .act_i(cmd == CMD_ACT), .ba_i(ba),
    .rrd_hit_o(rrd_hit), .faw_hit_o(faw_hit)
  );

  logic [3:0]      code_n;
  logic [BA_W-1:0] bank_n;

  always_comb begin
    code_n = RSN_NONE;
    bank_n = ba;
    unique case (cmd)
      CMD_RD, CMD_WR: begin
        if (!bk_open[ba])    code_n = RSN_IDLE_RW;
        else if (bk_rcd[ba]) code_n = RSN_RCD;
      end
      CMD_ACT: begin
        if (bk_open[ba])     code_n = RSN_OPEN;
        else if (bk_rc[ba])  code_n = RSN_RC;
        else if (rrd_hit)    code_n = RSN_RRD;
        else if (faw_hit)    code_n = RSN_FAW;
        else if (bk_rp[ba])  code_n = RSN_RP;
      end
      CMD_PRE: begin
        for (int i = NBANK - 1; i >= 0; i--) begin
          if (pre_tgt[i] && bk_open[i] && (bk_ras[i] || bk_rtp[i])) begin
            code_n = bk_ras[i] ? RSN_RAS : RSN_RTP;
            bank_n = BA_W'(i);
          end
        end
      end
      CMD_MRS, CMD_ZQ: begin
        for (int i = NBANK - 1; i >= 0; i--) begin
          if (bk_open[i]) begin
            code_n = RSN_CFG;
            bank_n = BA_W'(i);
          end
        end
      end
      default: code_n = RSN_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_o      <= 1'b0;
      viol_code_o <= RSN_NONE;
      viol_bank_o <= '0;
    end else begin
      viol_o      <= (code_n != RSN_NONE);
      viol_code_o <= code_n;
      viol_bank_o <= (code_n != RSN_NONE) ? bank_n : '0;
    end
  end
endmodule

// File: rtl/ddr_cmd_checker_chk.sv
module ddr_cmd_checker_chk #(
  parameter int BA_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            cke,
  input logic            cs_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic            viol_o,
  input logic [3:0]      viol_code_o,
  input logic [BA_W-1:0] viol_bank_o
);
  // R13
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !viol_o |-> (viol_code_o == 4'd0 && viol_bank_o == '0));
  // R13
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> (viol_code_o >= 4'd1 && viol_code_o <= 4'd10));
  // R13
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !viol_o);
  // R1
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n) || !$past(cke)) |-> !viol_o);
  // R1
  nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ras_n) && $past(cas_n) && $past(we_n)) |-> !viol_o);
  // R12
  cfg_source_chk: assert property (@(posedge clk) disable iff (rst)
    (viol_code_o == 4'd10) |-> (!$past(we_n) && ($past(ras_n) == $past(cas_n))));
  // R9 R10
  pre_source_chk: assert property (@(posedge clk) disable iff (rst)
    (viol_code_o == 4'd8 || viol_code_o == 4'd9) |->
      (!$past(ras_n) && $past(cas_n) && !$past(we_n)));
  // R2 R3
  col_source_chk: assert property (@(posedge clk) disable iff (rst)
    (viol_code_o == 4'd1 || viol_code_o == 4'd2) |-> ($past(ras_n) && !$past(cas_n)));
  // R4 R5 R6 R7 R8
  act_source_chk: assert property (@(posedge clk) disable iff (rst)
    (viol_code_o >= 4'd3 && viol_code_o <= 4'd7) |->
      (!$past(ras_n) && $past(cas_n) && $past(we_n)));
endmodule

bind ddr_cmd_checker ddr_cmd_checker_chk #(.BA_W(BA_W)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .viol_o(viol_o), .viol_code_o(viol_code_o), .viol_bank_o(viol_bank_o)
);

// File: tb/ddr_cmd_checker_bench.sv
module ddr_cmd_checker_bench;
  localparam logic [2:0] K_ACT = 3'b011, K_RD = 3'b101, K_WR = 3'b100, K_PRE = 3'b010,
                         K_MRS = 3'b000, K_ZQ = 3'b110, K_NOP = 3'b111;

  logic clk = 1'b0, rst = 1'b1, cke = 1'b1, cs_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0] ba = '0;
  logic [15:0] addr = '0;
  logic viol_o;
  logic [3:0] viol_code_o;
  logic [2:0] viol_bank_o;
  logic gv;
  logic [3:0] gc;
  logic [2:0] gb;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ddr_cmd_checker u_ddr_cmd_checker (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .viol_o(viol_o), .viol_code_o(viol_code_o),
    .viol_bank_o(viol_bank_o)
  );

  task automatic drive(input logic [2:0] k, input logic [2:0] b, input logic a10,
                       input logic csn = 1'b0, input logic ck = 1'b1);
    @(negedge clk);
    {ras_n, cas_n, we_n} = k;
    ba = b; addr = '0; addr[10] = a10; cs_n = csn; cke = ck;
    @(posedge clk);
    #1;
    gv = viol_o; gc = viol_code_o; gb = viol_bank_o;
  endtask

  // next command lands k cycles after the previous one
  task automatic gap(input int k);
    for (int i = 0; i < k - 1; i++) drive(K_NOP, 3'd0, 1'b0);
  endtask

  task automatic check(input string tag, input logic ev, input logic [3:0] ec, input logic [2:0] eb);
    n_chk++;
    if (gv !== ev || gc !== ec || gb !== eb) begin
      n_bad++;
      $display("FAIL %s: got v=%0d code=%0d bank=%0d, expected v=%0d code=%0d bank=%0d",
               tag, gv, gc, gb, ev, ec, eb);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; {ras_n, cas_n, we_n} = K_NOP; cs_n = 1'b0; cke = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    @(posedge clk); #1;
    gv = viol_o; gc = viol_code_o; gb = viol_bank_o;
    check("R13 reset", 0, 0, 0);
  endtask

  task automatic t_deselect();
    do_reset();
    drive(K_ACT, 3'd0, 1'b0, 1'b1, 1'b1); check("R1 cs_n high", 0, 0, 0);
    drive(K_ACT, 3'd0, 1'b0, 1'b0, 1'b0); check("R1 cke low", 0, 0, 0);
    drive(K_RD, 3'd0, 1'b0);              check("R1 bank still idle", 1, 1, 0);
  endtask

  task automatic t_idle_rw();
    do_reset();
    drive(K_WR, 3'd5, 1'b0);  check("R2 write idle", 1, 1, 5);
    drive(K_NOP, 3'd0, 1'b0); check("R13 one-cycle pulse", 0, 0, 0);
  endtask

  task automatic t_rcd();
    do_reset();
    drive(K_ACT, 3'd2, 1'b0); gap(13); drive(K_RD, 3'd2, 1'b0); check("R3 rcd early", 1, 2, 2);
    do_reset();
    drive(K_ACT, 3'd3, 1'b0); gap(14); drive(K_RD, 3'd3, 1'b0); check("R3 rcd met", 0, 0, 0);
  endtask

  task automatic t_open();
    do_reset();
    drive(K_ACT, 3'd1, 1'b0); gap(60); drive(K_ACT, 3'd1, 1'b0); check("R4 act open", 1, 3, 1);
  endtask

  task automatic t_rc();
    do_reset();
    drive(K_ACT, 3'd0, 1'b0); gap(36); drive(K_PRE, 3'd0, 1'b0); check("R9 ras met", 0, 0, 0);
    gap(13); drive(K_ACT, 3'd0, 1'b0); check("R5 rc early", 1, 4, 0);
  endtask

  task automatic t_rp();
    do_reset();
    drive(K_ACT, 3'd0, 1'b0); gap(40); drive(K_PRE, 3'd0, 1'b0);
    gap(13); drive(K_ACT, 3'd0, 1'b0); check("R8 rp early", 1, 7, 0);
    do_reset();
    drive(K_ACT, 3'd0, 1'b0); gap(40); drive(K_PRE, 3'd0, 1'b0);
    gap(14); drive(K_ACT, 3'd0, 1'b0); check("R8 rp met", 0, 0, 0);
    do_reset();
    drive(K_ACT, 3'd0, 1'b0); gap(36); drive(K_PRE, 3'd0, 1'b0);
    gap(10); drive(K_PRE, 3'd0, 1'b0); check("R8 pre idle quiet", 0, 0, 0);
    gap(4); drive(K_ACT, 3'd0, 1'b0); check("R8 pre idle no restart", 0, 0, 0);
  endtask

  task automatic t_rrd();
    do_reset();
    drive(K_ACT, 3'd0, 1'b0); gap(5); drive(K_ACT, 3'd1, 1'b0); check("R6 rrd early", 1, 5, 1);
    gap(6); drive(K_ACT, 3'd2, 1'b0); check("R6 rrd met", 0, 0, 0);
  endtask

  task automatic t_faw();
    do_reset();
    drive(K_ACT, 3'd0, 1'b0);
    for (int b = 1; b < 4; b++) begin gap(6); drive(K_ACT, 3'(b), 1'b0); end
    check("R7 fourth act ok", 0, 0, 0);
    gap(6); drive(K_ACT, 3'd4, 1'b0); check("R7 fifth in window", 1, 6, 4);
    do_reset();
    drive(K_ACT, 3'd0, 1'b0);
    for (int b = 1; b < 5; b++) begin gap(7); drive(K_ACT, 3'(b), 1'b0); end
    check("R7 fifth outside window", 0, 0, 0);
  endtask

  task automatic t_ras_rtp();
    do_reset();
    drive(K_ACT, 3'd6, 1'b0); gap(35); drive(K_PRE, 3'd6, 1'b0); check("R9 ras early", 1, 8, 6);
    do_reset();
    drive(K_ACT, 3'd7, 1'b0); gap(30); drive(K_RD, 3'd7, 1'b0); check("R10 read ok", 0, 0, 0);
    gap(7); drive(K_PRE, 3'd7, 1'b0); check("R10 rtp early", 1, 9, 7);
    do_reset();
    drive(K_ACT, 3'd7, 1'b0); gap(30); drive(K_RD, 3'd7, 1'b0);
    gap(8); drive(K_PRE, 3'd7, 1'b0); check("R10 rtp met", 0, 0, 0);
  endtask

  task automatic t_autopre();
    // READ+AP at 40: earliest precharge 48, activate legal at 62
    do_reset();
    drive(K_ACT, 3'd2, 1'b0); gap(40); drive(K_RD, 3'd2, 1'b1); check("R11 read ap ok", 0, 0, 0);
    gap(1); drive(K_RD, 3'd2, 1'b0); check("R11 bank closed", 1, 1, 2);
    gap(20); drive(K_ACT, 3'd2, 1'b0); check("R11 act at 61", 1, 7, 2);
    do_reset();
    drive(K_ACT, 3'd2, 1'b0); gap(40); drive(K_RD, 3'd2, 1'b1);
    gap(22); drive(K_ACT, 3'd2, 1'b0); check("R11 act at 62", 0, 0, 0);
    // WRITE+AP at 14: earliest precharge 36, activate legal at 50
    do_reset();
    drive(K_ACT, 3'd5, 1'b0); gap(14); drive(K_WR, 3'd5, 1'b1);
    gap(1); drive(K_WR, 3'd5, 1'b0); check("R11 write ap closed", 1, 1, 5);
    gap(35); drive(K_ACT, 3'd5, 1'b0); check("R11 act after write ap", 0, 0, 0);
  endtask

  task automatic t_cfg();
    do_reset();
    drive(K_MRS, 3'd0, 1'b0); check("R12 mrs all idle", 0, 0, 0);
    drive(K_ZQ, 3'd0, 1'b1);  check("R12 zq all idle", 0, 0, 0);
    drive(K_ACT, 3'd5, 1'b0); gap(6); drive(K_ACT, 3'd3, 1'b0);
    gap(6); drive(K_MRS, 3'd1, 1'b0); check("R12 mrs lowest open", 1, 10, 3);
    do_reset();
    drive(K_ACT, 3'd6, 1'b0); gap(6); drive(K_ZQ, 3'd0, 1'b1); check("R12 zq open", 1, 10, 6);
  endtask

  task automatic t_pre_all();
    do_reset();
    drive(K_ACT, 3'd1, 1'b0); gap(6); drive(K_ACT, 3'd4, 1'b0);
    gap(34); drive(K_PRE, 3'd0, 1'b1); check("R14 pre all ras", 1, 8, 4);
    gap(1); drive(K_RD, 3'd1, 1'b0); check("R14 all closed", 1, 1, 1);
  endtask

  initial begin
    t_reset_state();
    t_deselect();
    t_idle_rw();
    t_rcd();
    t_open();
    t_rc();
    t_rp();
    t_rrd();
    t_faw();
    t_ras_rtp();
    t_autopre();
    t_cfg();
    t_pre_all();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule